// File: doc/BRIEF.md
# Queued Serial Peripheral Master

This block is an SPI master driven from a small synchronous register bus. Software fills up to sixteen queue slots. Each slot has a command word, a pair of transmit bytes and a pair of receive bytes. Software then picks a start and an end slot and writes a go bit. The engine walks the slots in order and shifts 8 or 16 bits per slot, most significant bit first, on a single data line in each direction. Each slot's own continue flag decides whether chip select stays low between that slot and the next. When the end slot has finished, the engine raises a completion flag and stores the received bytes where software can read them back.

A transaction longer than the queue is split into several runs. When a run is started with the hold flag, chip select stays low after its end slot, so the next run carries on the same transaction without a break. A lock bit is provided that software sets for the length of such a multi-run transaction. The serial clock rate comes from a divider register. Its value is clamped to a legal window before use.

Register map (word addresses on `bus_addr`):
- 0x00 go/hold: bit0 starts a run; bit1 is the hold flag. Reading returns bit0 = running, bit1 = hold flag.
- 0x01 mode: bit0 = clock phase, bit1 = clock polarity.
- 0x02 divider.
- 0x03 pointers: bits 3:0 = start slot, bits 11:8 = end slot.
- 0x04 status: bit0 = complete. Any write clears it.
- 0x05 lock: bit0.
- 0x40+i: command word of slot i.
- 0x80+n: transmit byte n.
- 0xC0+n: receive byte n.

Top module: `qspim_top`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and the go/hold register and the status register both read 0.
- R2: Each serial clock half period lasts D system clock cycles. D is the divider register value clamped to the range DIV_MIN..DIV_MAX (defaults 2 and 200). A divider of 0 gives 2, and 250 gives 200.
- R3: A run processes the slots from the start pointer to the end pointer inclusive. The slot index increases by one and wraps from 15 to 0.
- R4: In a slot whose command bit1 is 0, the engine sends 8 bits from transmit byte 2i and stores the 8 received bits in receive byte 2i+1. Transmit byte 2i+1 is not sent.
- R5: In a slot whose command bit1 is 1, the engine sends 16 bits: byte 2i first, then byte 2i+1. The first received byte goes to receive byte 2i and the second to 2i+1.
- R6: After a slot that is not the end slot, chip select stays low if command bit0 (continue) is 1. If bit0 is 0, chip select goes high for at least one half period before the next slot.
- R7: After the end slot, chip select stays low if the slot's continue bit or the run's hold flag is set. Otherwise it goes high.
- R8: When the end slot finishes, the running bit returns to 0 and status bit0 becomes 1. A write to status clears status bit0.
- R9: While idle, the serial clock rests at the polarity bit. With phase 0, data is sampled on the leading edge of each clock pulse; with phase 1, on the trailing edge. The outgoing bit changes on the other edge.
- R10: While a run is active, writes to the command, transmit, mode, divider and pointer locations have no effect.
- R11: The lock bit reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions check on every cycle that chip select is low whenever bits are shifting and that the outgoing bit never changes on a sampling edge. They also check that the idle clock level follows the polarity bit, that divider ticks never come back to back, that completion always sets the status bit, and that the pointer and divider settings stay frozen while a run is active. Only the bench scenarios can show the byte placement of narrow and wide slots and the pointer wrap. The same goes for chip-select behaviour across slots and across chained runs, the measured half-period lengths at both clamp limits, and the fact that writes during a run leave the queue contents untouched.

// File: rtl/qspim_pkg.sv
package qspim_pkg;

  // Bus address regions, selected by bus_addr[7:6]
  localparam logic [1:0] RG_CFG = 2'd0;
  localparam logic [1:0] RG_CMD = 2'd1;
  localparam logic [1:0] RG_TX  = 2'd2;
  localparam logic [1:0] RG_RX  = 2'd3;

  // Configuration word offsets inside RG_CFG
  localparam logic [5:0] REG_GO   = 6'h00;
  localparam logic [5:0] REG_MODE = 6'h01;
  localparam logic [5:0] REG_DIV  = 6'h02;
  localparam logic [5:0] REG_QPTR = 6'h03;
  localparam logic [5:0] REG_STAT = 6'h04;
  localparam logic [5:0] REG_LOCK = 6'h05;

  // Per-slot command: bit1 = 16-bit slot, bit0 = keep select low afterwards
  typedef struct packed {
    logic wide;
    logic cont;
  } slot_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_SHIFT,
    ST_STORE,
    ST_GAP
  } eng_state_e;

endpackage

// File: rtl/qspim_sdpram.sv
module qspim_sdpram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Single write port, single registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/qspim_clkdiv.sv
module qspim_clkdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            restart,
  input  logic [DIVW-1:0] div,
  output logic            tick
);

  logic [DIVW-1:0] cnt;

  assign tick = run && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart || !run || cnt == '0) begin
      cnt <= div - 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2: a half period of at least two cycles never yields adjacent ticks
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && div > 1) |=> !tick);

endmodule

// File: rtl/qspim_engine.sv
module qspim_engine
  import qspim_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          keep,
  input  logic [SW-1:0] qstart,
  input  logic [SW-1:0] qend,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          tick,
  output logic          clk_run,
  output logic          clk_restart,
  output logic [SW-1:0] slot_addr,
  input  logic [1:0]    cmd_word,
  input  logic [7:0]    tx_even,
  input  logic [7:0]    tx_odd,
  output logic          rx_we_even,
  output logic          rx_we_odd,
  output logic [SW-1:0] rx_addr,
  output logic [7:0]    rx_even,
  output logic [7:0]    rx_odd,
  output logic          busy,
  output logic          done_pulse,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  input  logic          miso
);

  eng_state_e    state;
  logic [SW-1:0] slot;
  logic          cur_wide;
  logic          cur_cont;
  logic          keep_q;
  logic [5:0]    edge_cnt;
  logic [5:0]    last_edge;
  logic [15:0]   txsr;
  logic [15:0]   rxsr;
  logic [15:0]   load_word;
  logic          lead_edge;
  logic          sample_edge;
  slot_cmd_t     cmd;

  assign cmd         = slot_cmd_t'(cmd_word);
  assign slot_addr   = slot;
  assign busy        = (state != ST_IDLE);
  assign clk_run     = (state == ST_SHIFT) || (state == ST_GAP);
  assign clk_restart = (state == ST_LOAD) || (state == ST_STORE);
  assign last_edge   = cur_wide ? 6'd31 : 6'd15;
  assign load_word   = cmd.wide ? {tx_even, tx_odd} : {tx_even, 8'h00};
  assign lead_edge   = !edge_cnt[0];
  assign sample_edge = lead_edge ^ cpha;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      slot       <= '0;
      cur_wide   <= 1'b0;
      cur_cont   <= 1'b0;
      keep_q     <= 1'b0;
      edge_cnt   <= '0;
      txsr       <= '0;
      rxsr       <= '0;
      sclk       <= 1'b0;
      mosi       <= 1'b0;
      cs_n       <= 1'b1;
      done_pulse <= 1'b0;
      rx_we_even <= 1'b0;
      rx_we_odd  <= 1'b0;
      rx_addr    <= '0;
      rx_even    <= '0;
      rx_odd     <= '0;
    end else begin
      done_pulse <= 1'b0;
      rx_we_even <= 1'b0;
      rx_we_odd  <= 1'b0;
      case (state)
        ST_IDLE: begin
          sclk <= cpol;
          if (start) begin
            slot   <= qstart;
            keep_q <= keep;
            state  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          // RAM read of the current slot completes at the end of this cycle
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          cur_wide <= cmd.wide;
          cur_cont <= cmd.cont;
          edge_cnt <= '0;
          sclk     <= cpol;
          cs_n     <= 1'b0;
          if (!cpha) begin
            mosi <= load_word[15];
            txsr <= {load_word[14:0], 1'b0};
          end else begin
            txsr <= load_word;
          end
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk     <= ~sclk;
            edge_cnt <= edge_cnt + 1'b1;
            if (sample_edge) begin
              rxsr <= {rxsr[14:0], miso};
            end else if (edge_cnt != last_edge) begin
              mosi <= txsr[15];
              txsr <= {txsr[14:0], 1'b0};
            end
            if (edge_cnt == last_edge) state <= ST_STORE;
          end
        end
        ST_STORE: begin
          rx_addr    <= slot;
          rx_we_odd  <= 1'b1;
          rx_we_even <= cur_wide;
          rx_odd     <= rxsr[7:0];
          rx_even    <= rxsr[15:8];
          if (slot == qend) begin
            done_pulse <= 1'b1;
            cs_n       <= ~(cur_cont | keep_q);
            state      <= ST_IDLE;
          end else begin
            slot <= slot + 1'b1;
            if (cur_cont) begin
              state <= ST_FETCH;
            end else begin
              cs_n  <= 1'b1;
              state <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (tick) state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: select is asserted for the whole shifting phase
  p_cs_low_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> !cs_n);

  // R9: the outgoing bit is held across a sampling edge
  p_mosi_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && tick && sample_edge) |=> $stable(mosi));

  // R9: the idle clock level follows the polarity setting
  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_IDLE && $stable(cpol)) |-> (sclk == cpol));

  // R8: completion is only signalled as the engine returns to idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (state == ST_IDLE && $past(state) == ST_STORE));

endmodule

// File: rtl/qspim_top.sv
module qspim_top
  import qspim_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int DIVW    = 8,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n,
  input  logic        spi_miso
);

  localparam int SW = $clog2(SLOTS);
  localparam logic [DIVW-1:0] DMIN = DIVW'(DIV_MIN);
  localparam logic [DIVW-1:0] DMAX = DIVW'(DIV_MAX);

  // Bus decode
  logic [1:0] region;
  logic [5:0] idx;
  logic       wr;
  logic       cmd_hit;
  logic       tx_hit;
  logic       locked_out;

  assign region  = bus_addr[7:6];
  assign idx     = bus_addr[5:0];
  assign wr      = bus_en && bus_we;
  assign cmd_hit = ({1'b0, idx} < 7'(SLOTS));
  assign tx_hit  = ({1'b0, idx} < 7'(2 * SLOTS));

  // Configuration state
  logic          cpol, cpha, keep_cfg, stat_done, lock_bit, start_q;
  logic [DIVW-1:0] div_raw, div_eff;
  logic [SW-1:0] qstart, qend;

  // Engine side
  logic          busy, done_pulse, tick, clk_run, clk_restart;
  logic [SW-1:0] slot_addr, rx_waddr;
  logic [1:0]    cmd_rd;
  logic [7:0]    tx_rd [2];
  logic [7:0]    rx_rd [2];
  logic [7:0]    rx_wd [2];
  logic          rx_we [2];

  assign locked_out = busy || start_q;

  always_comb begin
    if (div_raw < DMIN)      div_eff = DMIN;
    else if (div_raw > DMAX) div_eff = DMAX;
    else                     div_eff = div_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpol      <= 1'b0;
      cpha      <= 1'b0;
      keep_cfg  <= 1'b0;
      stat_done <= 1'b0;
      lock_bit  <= 1'b0;
      start_q   <= 1'b0;
      div_raw   <= '0;
      qstart    <= '0;
      qend      <= '0;
    end else begin
      start_q <= 1'b0;
      if (done_pulse) begin
        stat_done <= 1'b1;
      end else if (wr && region == RG_CFG && idx == REG_STAT) begin
        stat_done <= 1'b0;
      end
      if (wr && region == RG_CFG) begin
        case (idx)
          REG_GO: begin
            if (!locked_out && bus_wdata[0]) begin
              start_q  <= 1'b1;
              keep_cfg <= bus_wdata[1];
            end
          end
          REG_MODE: begin
            if (!locked_out) begin
              cpha <= bus_wdata[0];
              cpol <= bus_wdata[1];
            end
          end
          REG_DIV: begin
            if (!locked_out) div_raw <= bus_wdata[DIVW-1:0];
          end
          REG_QPTR: begin
            if (!locked_out) begin
              qstart <= bus_wdata[SW-1:0];
              qend   <= bus_wdata[8 +: SW];
            end
          end
          REG_LOCK: lock_bit <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // Read path: one cycle of latency for registers and receive RAM alike
  logic [1:0]  rd_region_q;
  logic        rd_byte_q;
  logic [31:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_region_q <= RG_CFG;
      rd_byte_q   <= 1'b0;
      reg_q       <= '0;
    end else begin
      rd_region_q <= region;
      rd_byte_q   <= idx[0];
      reg_q       <= '0;
      if (bus_en && !bus_we && region == RG_CFG) begin
        case (idx)
          REG_GO:   reg_q <= {30'd0, keep_cfg, locked_out};
          REG_MODE: reg_q <= {30'd0, cpol, cpha};
          REG_DIV:  reg_q <= 32'(div_raw);
          REG_QPTR: reg_q <= 32'(qstart) | (32'(qend) << 8);
          REG_STAT: reg_q <= {31'd0, stat_done};
          REG_LOCK: reg_q <= {31'd0, lock_bit};
          default:  reg_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = (rd_region_q == RG_RX)
                   ? {24'd0, rx_rd[rd_byte_q]}
                   : reg_q;

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:8 + SW], bus_wdata[7:DIVW > SW ? DIVW : SW]};

  // Command RAM
  qspim_sdpram #(.WIDTH(2), .DEPTH(SLOTS)) u_cmd_ram (
    .clk   (clk),
    .we    (wr && region == RG_CMD && cmd_hit && !locked_out),
    .waddr (idx[SW-1:0]),
    .wdata (bus_wdata[1:0]),
    .raddr (slot_addr),
    .rdata (cmd_rd)
  );

  // Byte banks: bank 0 holds even byte positions, bank 1 odd ones
  for (genvar b = 0; b < 2; b++) begin : g_bank
    qspim_sdpram #(.WIDTH(8), .DEPTH(SLOTS)) u_tx (
      .clk   (clk),
      .we    (wr && region == RG_TX && tx_hit && !locked_out && (idx[0] == 1'(b))),
      .waddr (idx[SW:1]),
      .wdata (bus_wdata[7:0]),
      .raddr (slot_addr),
      .rdata (tx_rd[b])
    );
    qspim_sdpram #(.WIDTH(8), .DEPTH(SLOTS)) u_rx (
      .clk   (clk),
      .we    (rx_we[b]),
      .waddr (rx_waddr),
      .wdata (rx_wd[b]),
      .raddr (idx[SW:1]),
      .rdata (rx_rd[b])
    );
  end

  qspim_clkdiv #(.DIVW(DIVW)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (clk_run),
    .restart (clk_restart),
    .div     (div_eff),
    .tick    (tick)
  );

  qspim_engine #(.SLOTS(SLOTS)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .start       (start_q),
    .keep        (keep_cfg),
    .qstart      (qstart),
    .qend        (qend),
    .cpol        (cpol),
    .cpha        (cpha),
    .tick        (tick),
    .clk_run     (clk_run),
    .clk_restart (clk_restart),
    .slot_addr   (slot_addr),
    .cmd_word    (cmd_rd),
    .tx_even     (tx_rd[0]),
    .tx_odd      (tx_rd[1]),
    .rx_we_even  (rx_we[0]),
    .rx_we_odd   (rx_we[1]),
    .rx_addr     (rx_waddr),
    .rx_even     (rx_wd[0]),
    .rx_odd      (rx_wd[1]),
    .busy        (busy),
    .done_pulse  (done_pulse),
    .sclk        (spi_sclk),
    .mosi        (spi_mosi),
    .cs_n        (spi_cs_n),
    .miso        (spi_miso)
  );

  // R8: completion always lands in the status bit
  p_done_status_r8: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> stat_done);

  // R10: pointers and divider are frozen while a run is active
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    $past(locked_out) |-> ($stable(qend) && $stable(qstart) && $stable(div_raw)));

endmodule

// File: tb/qspim_top_test.sv
module qspim_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_cs_n, spi_miso;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qspim_top uut (
    .clk (clk), .rst (rst), .bus_en (bus_en), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .spi_sclk (spi_sclk), .spi_mosi (spi_mosi), .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso)
  );

  // Slave model: shifts a response stream out and captures the master's bits
  logic        tb_cpol = 1'b0;
  logic        tb_cpha = 1'b0;
  logic [63:0] resp_sr = '0;
  logic [63:0] cap = '0;
  int          edges = 0;
  int          cs_falls = 0;
  int          cyc = 0;
  int          last_edge_cyc = 0;
  int          last_gap = 0;

  assign spi_miso = resp_sr[63];

  always @(negedge clk) cyc++;

  always @(spi_sclk) begin
    if (!spi_cs_n) begin
      edges++;
      last_gap = cyc - last_edge_cyc;
      last_edge_cyc = cyc;
      if ((spi_sclk != tb_cpol) ^ tb_cpha) begin
        cap = {cap[62:0], spi_mosi};
        resp_sr = {resp_sr[62:0], 1'b0};
      end
    end
  end

  always @(negedge spi_cs_n) cs_falls++;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic arm(input logic pol, input logic pha, input logic [63:0] resp);
    tb_cpol = pol; tb_cpha = pha;
    resp_sr = resp; cap = '0; edges = 0; cs_falls = 0; last_gap = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      br(8'h00, d);
      if (!d[0]) break;
    end
  endtask

  task automatic go(input logic hold);
    bw(8'h00, {30'd0, hold, 1'b1});
    wait_idle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "cs_n", 64'(spi_cs_n), 64'd1);
    chk("R1", "sclk", 64'(spi_sclk), 64'd0);
    br(8'h00, d); chk("R1", "go reg", 64'(d), 64'd0);
    br(8'h04, d); chk("R1", "status", 64'(d), 64'd0);
  endtask

  // Three narrow slots, all held together, mode 0, divider 0 clamps to 2
  task automatic t_narrow();
    logic [31:0] d;
    bw(8'h40, 32'h1); bw(8'h41, 32'h1); bw(8'h42, 32'h0);
    bw(8'h80, 32'hA5); bw(8'h81, 32'hFF);
    bw(8'h82, 32'h3C); bw(8'h83, 32'hFF);
    bw(8'h84, 32'h81); bw(8'h85, 32'hFF);
    bw(8'h03, 32'h0200);
    arm(1'b0, 1'b0, 64'hC35A96_00_0000_0000);
    go(1'b0);
    chk("R4", "narrow mosi stream", cap[23:0], 64'hA53C81);
    chk("R6", "select held across continued slots", 64'(cs_falls), 64'd1);
    chk("R2", "half period at min clamp", 64'(last_gap), 64'd2);
    chk("R4", "clock edges for 3 narrow slots", 64'(edges), 64'd48);
    chk("R7", "select released after end slot", 64'(spi_cs_n), 64'd1);
    br(8'hC1, d); chk("R4", "rx byte 1", 64'(d), 64'hC3);
    br(8'hC3, d); chk("R4", "rx byte 3", 64'(d), 64'h5A);
    br(8'hC5, d); chk("R4", "rx byte 5", 64'(d), 64'h96);
    br(8'h00, d); chk("R8", "go bit self-cleared", 64'(d[0]), 64'd0);
    br(8'h04, d); chk("R8", "status complete set", 64'(d[0]), 64'd1);
    bw(8'h04, 32'h0);
    br(8'h04, d); chk("R8", "status cleared by write", 64'(d[0]), 64'd0);
  endtask

  // Two wide slots in mode 3 with a select gap between them
  task automatic t_wide();
    logic [31:0] d;
    bw(8'h01, 32'h3);
    repeat (3) @(negedge clk);
    chk("R9", "idle clock high for polarity 1", 64'(spi_sclk), 64'd1);
    bw(8'h02, 32'd5);
    bw(8'h44, 32'h2); bw(8'h45, 32'h2);
    bw(8'h88, 32'h12); bw(8'h89, 32'h34);
    bw(8'h8A, 32'h56); bw(8'h8B, 32'h78);
    bw(8'h03, 32'h0504);
    arm(1'b1, 1'b1, 64'hDEADBEEF_0000_0000);
    go(1'b0);
    chk("R5", "wide mosi stream", cap[31:0], 64'h12345678);
    chk("R6", "select reasserted after gap", 64'(cs_falls), 64'd2);
    chk("R2", "half period with divider 5", 64'(last_gap), 64'd5);
    chk("R9", "clock back at idle high", 64'(spi_sclk), 64'd1);
    br(8'hC8, d); chk("R5", "rx byte 8", 64'(d), 64'hDE);
    br(8'hC9, d); chk("R5", "rx byte 9", 64'(d), 64'hAD);
    br(8'hCA, d); chk("R5", "rx byte 10", 64'(d), 64'hBE);
    br(8'hCB, d); chk("R5", "rx byte 11", 64'(d), 64'hEF);
  endtask

  // Mode 2: idle high, sample on the leading (falling) edge
  task automatic t_mode2();
    logic [31:0] d;
    bw(8'h01, 32'h2);
    bw(8'h48, 32'h0); bw(8'h90, 32'hC6); bw(8'h03, 32'h0808);
    arm(1'b1, 1'b0, 64'h3B00_0000_0000_0000);
    go(1'b0);
    chk("R9", "mode 2 mosi", cap[7:0], 64'hC6);
    br(8'hD1, d); chk("R9", "mode 2 rx byte 17", 64'(d), 64'h3B);
  endtask

  // Wrapping pointers plus a held run chained to a second run (mode 1)
  task automatic t_chain();
    logic [31:0] d;
    bw(8'h05, 32'h1);
    br(8'h05, d); chk("R11", "lock set", 64'(d[0]), 64'd1);
    bw(8'h01, 32'h1);
    bw(8'h4F, 32'h1); bw(8'h40, 32'h0); bw(8'h41, 32'h0);
    bw(8'h9E, 32'h9C); bw(8'h80, 32'h27); bw(8'h82, 32'hE1);
    bw(8'h03, 32'h000F);
    repeat (3) @(negedge clk);
    arm(1'b0, 1'b1, 64'h1F2E3D_00_0000_0000);
    go(1'b1);
    chk("R7", "select held by hold flag", 64'(spi_cs_n), 64'd0);
    chk("R3", "wrapped run length", 64'(edges), 64'd32);
    bw(8'h03, 32'h0101);
    go(1'b0);
    chk("R7", "select released by final run", 64'(spi_cs_n), 64'd1);
    chk("R7", "one select assertion across runs", 64'(cs_falls), 64'd1);
    chk("R3", "slots 15,0 then 1 in order", cap[23:0], 64'h9C27E1);
    br(8'hDF, d); chk("R3", "rx byte 31", 64'(d), 64'h1F);
    br(8'hC1, d); chk("R3", "rx byte 1", 64'(d), 64'h2E);
    br(8'hC3, d); chk("R3", "rx byte 3", 64'(d), 64'h3D);
    bw(8'h05, 32'h0);
    br(8'h05, d); chk("R11", "lock cleared", 64'(d[0]), 64'd0);
  endtask

  // Writes during a run are dropped; divider 250 clamps to 200
  task automatic t_busy();
    bw(8'h01, 32'h0);
    bw(8'h02, 32'd250);
    bw(8'h46, 32'h0); bw(8'h47, 32'h0);
    bw(8'h8C, 32'h5A); bw(8'h8E, 32'h11);
    bw(8'h03, 32'h0606);
    repeat (3) @(negedge clk);
    arm(1'b0, 1'b0, 64'h0);
    bw(8'h00, 32'h1);
    bw(8'h8E, 32'h77);
    bw(8'h03, 32'h0707);
    bw(8'h02, 32'd3);
    bw(8'h46, 32'h2);
    wait_idle();
    chk("R4", "slot 6 mosi", cap[7:0], 64'h5A);
    chk("R10", "pointer write ignored (one slot)", 64'(edges), 64'd16);
    chk("R2", "half period at max clamp, divider write ignored", 64'(last_gap), 64'd200);
    bw(8'h02, 32'd3);
    bw(8'h03, 32'h0707);
    arm(1'b0, 1'b0, 64'h0);
    go(1'b0);
    chk("R10", "tx byte write during run ignored", cap[7:0], 64'h11);
    chk("R2", "half period with divider 3", 64'(last_gap), 64'd3);
    bw(8'h03, 32'h0606);
    arm(1'b0, 1'b0, 64'h0);
    go(1'b0);
    chk("R10", "command write during run ignored", 64'(edges), 64'd16);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_narrow();
    t_wide();
    t_mode2();
    t_chain();
    t_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL R8 watchdog: actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule